// File: doc/BRIEF.md
# Compacted State-Restore Sequencer

This block controls a privileged restore of processor state components from a save area in memory that uses the compacted layout. A single `start_i` pulse launches the restore. The block first registers the operand set: a 64-bit instruction mask, the user and supervisor feature-enable masks, the privilege level, the extension-enable bit, the task-switched bit and the save-area address. It then runs the entry checks in a fixed priority order. If no entry check fails, it reads the 64-byte header as eight 64-bit words and validates it. If the header is valid, it walks through the requested components.

For each requested component, the block issues exactly one command on a ready/valid port. The command either returns the component to its initial configuration or loads the component from the save area. The component contents and the payload transfers belong to other blocks. At the end of the run the block pulses `done_o` and reports a two-bit fault code. There is no path for a save area in the standard (non-compacted) layout.

Top module: `restore_seq`

## Requirements
- R1: The requested set is `instr_mask_i & (user_en_i | sup_en_i)`, registered at start. Only bits 0 to 62 name components. Bit 63 never produces a command.
- R2: When `ext_en_i` is 0, the run ends with fault code 1 (invalid opcode), whatever the other inputs are.
- R3: When `ext_en_i` is 1 and `task_sw_i` is 1, the run ends with fault code 2 (device not available), whatever the privilege level and the address are.
- R4: When the first two checks pass, a nonzero `priv_i` or a nonzero `area_addr_i[5:0]` ends the run with fault code 3 (general protection).
- R5: The header is read only when all entry checks pass. The block then makes exactly eight word reads, at `area_addr_i + 8*k` for k = 0..7 in ascending order. Word 0 is the state-present vector and word 1 is the compaction vector. A run that fails an entry check makes no read.
- R6: The header ends the run with fault code 3 in any of these cases: compaction bit 63 is 0; the compaction vector sets a bit in 62:0 that is clear in `user_en_i | sup_en_i`; the state-present vector sets any bit, including bit 63, that is clear in the compaction vector; or any of words 2 to 7 is nonzero.
- R7: On a valid header, one command is issued for each requested component, in ascending index order. `cmd_load_o` is 1 (load) when state-present bit i is 1, and 0 (initialize) when that bit is 0, even if compaction bit i is also 0. The index and the kind stay stable while `cmd_valid_o` is waiting for `cmd_ready_i`.
- R8: A command that initializes component 1 raises `cmd_csr_init_o` and drives `csr_val_o` = 0x1F80. Every other command leaves `cmd_csr_init_o` at 0.
- R9: `done_o` is a one-cycle pulse that marks the end of the run. `fault_o` carries 0 none, 1 invalid opcode, 2 device not available, or 3 general protection. A faulting run issues no command. After reset, `busy_o`, `done_o`, `cmd_valid_o` and `rd_req_o` are 0.
- R10: `start_i` is ignored while `busy_o` is 1. The inputs registered at the first start decide the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse |
| instr_mask_i | input | 64 | Instruction mask |
| user_en_i | input | 64 | User feature-enable mask |
| sup_en_i | input | 64 | Supervisor feature-enable mask |
| priv_i | input | 2 | Current privilege level |
| ext_en_i | input | 1 | Extension enabled |
| task_sw_i | input | 1 | Task-switched flag |
| area_addr_i | input | 64 | Save-area byte address |
| rd_req_o | output | 1 | Header word read request |
| rd_addr_o | output | 64 | Header word byte address |
| rd_valid_i | input | 1 | Read data valid; completes the current request |
| rd_data_i | input | 64 | Read data word |
| cmd_valid_o | output | 1 | Component command valid |
| cmd_ready_i | input | 1 | Component command accepted |
| cmd_load_o | output | 1 | 1 = load from memory, 0 = initialize |
| cmd_idx_o | output | 6 | Component index |
| cmd_csr_init_o | output | 1 | Control/status register initial value applies |
| csr_val_o | output | 32 | Control/status register initial value |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| fault_o | output | 2 | Fault code of the last run |

## Verification
The bench uses the default parameters: 63 components, 64-bit header words, an eight-word header and a 64-bit address. With these values, component 62 can be reached as the highest index, and bit 63 can be exercised both as a mask bit with no component and as a header bit that must be checked. The full eight-word header is read, so every tail word can be checked for the nonzero-tail fault. The bench applies back-pressure on both the read port and the command port. This exercises the hold behaviour of the command port and the ascending order of the reads under stalls.

// File: rtl/restore_pkg.sv
package restore_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_NM   = 2'd2,
    FLT_GP   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHECK,
    S_ISSUE,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/rs_entry_check.sv
module rs_entry_check
  import restore_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int ALIGN_W = 6
) (
  input  logic              ext_en_i,
  input  logic              task_sw_i,
  input  logic [1:0]        priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output fault_e            fault_o
);
  always_comb begin
    if (!ext_en_i)                                     fault_o = FLT_UD;
    else if (task_sw_i)                                fault_o = FLT_NM;
    else if (priv_i != 2'd0 || addr_i[ALIGN_W-1:0] != '0) fault_o = FLT_GP;
    else                                               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/rs_header_check.sv
module rs_header_check #(
  parameter int W = 64
) (
  input  logic [W-1:0] state_vec_i,
  input  logic [W-1:0] comp_vec_i,
  input  logic [W-1:0] enable_i,
  input  logic         tail_nz_i,
  output logic         bad_o
);
  logic no_compact, comp_extra, state_extra;

  assign no_compact  = !comp_vec_i[W-1];
  assign comp_extra  = |(comp_vec_i[W-2:0] & ~enable_i[W-2:0]);
  assign state_extra = |(state_vec_i & ~comp_vec_i);
  assign bad_o       = no_compact | comp_extra | state_extra | tail_nz_i;
endmodule

// File: rtl/rs_next_bit.sv
module rs_next_bit #(
  parameter int N  = 63,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] from_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && i >= int'(from_i)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/restore_seq.sv
module restore_seq
  import restore_pkg::*;
#(
  parameter int          NCOMP     = 63,
  parameter int          WORD_W    = 64,
  parameter int          HDR_WORDS = 8,
  parameter int          ADDR_W    = 64,
  parameter int          ALIGN_W   = 6,
  parameter int          CSR_W     = 32,
  parameter logic [31:0] CSR_INIT  = 32'h0000_1F80,
  parameter int          CSR_IDX   = 1,
  localparam int         IW        = $clog2(NCOMP + 1),
  localparam int         CW        = $clog2(HDR_WORDS),
  localparam int         BSH       = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] instr_mask_i,
  input  logic [WORD_W-1:0] user_en_i,
  input  logic [WORD_W-1:0] sup_en_i,
  input  logic [1:0]        priv_i,
  input  logic              ext_en_i,
  input  logic              task_sw_i,
  input  logic [ADDR_W-1:0] area_addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_load_o,
  output logic [IW-1:0]     cmd_idx_o,
  output logic              cmd_csr_init_o,
  output logic [CSR_W-1:0]  csr_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        fault_o
);
  seq_state_e        st_q;
  fault_e            fault_q, entry_fault;
  logic [NCOMP-1:0]  rfbm_q;
  logic [WORD_W-1:0] en_q, state_q, comp_q;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     wcnt_q;
  logic              tail_nz_q;
  logic [IW-1:0]     cur_q, nxt_idx;
  logic              nxt_found, hdr_bad;

  rs_entry_check #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_entry (
    .ext_en_i (ext_en_i),
    .task_sw_i(task_sw_i),
    .priv_i   (priv_i),
    .addr_i   (area_addr_i),
    .fault_o  (entry_fault)
  );

  rs_header_check #(.W(WORD_W)) u_hdr (
    .state_vec_i(state_q),
    .comp_vec_i (comp_q),
    .enable_i   (en_q),
    .tail_nz_i  (tail_nz_q),
    .bad_o      (hdr_bad)
  );

  rs_next_bit #(.N(NCOMP), .IW(IW)) u_scan (
    .req_i  (rfbm_q),
    .from_i (cur_q),
    .found_o(nxt_found),
    .idx_o  (nxt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      fault_q   <= FLT_NONE;
      rfbm_q    <= '0;
      en_q      <= '0;
      state_q   <= '0;
      comp_q    <= '0;
      base_q    <= '0;
      wcnt_q    <= '0;
      tail_nz_q <= 1'b0;
      cur_q     <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          rfbm_q    <= instr_mask_i[NCOMP-1:0] & (user_en_i[NCOMP-1:0] | sup_en_i[NCOMP-1:0]);
          en_q      <= user_en_i | sup_en_i;
          base_q    <= area_addr_i;
          wcnt_q    <= '0;
          tail_nz_q <= 1'b0;
          fault_q   <= entry_fault;
          st_q      <= (entry_fault != FLT_NONE) ? S_DONE : S_READ;
        end
        S_READ: if (rd_valid_i) begin
          if (wcnt_q == CW'(0))      state_q <= rd_data_i;
          else if (wcnt_q == CW'(1)) comp_q  <= rd_data_i;
          else                       tail_nz_q <= tail_nz_q | (|rd_data_i);
          if (wcnt_q == CW'(HDR_WORDS - 1)) st_q <= S_CHECK;
          else                              wcnt_q <= wcnt_q + 1'b1;
        end
        S_CHECK: begin
          cur_q <= '0;
          if (hdr_bad) begin
            fault_q <= FLT_GP;
            st_q    <= S_DONE;
          end else begin
            st_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!nxt_found) begin
            fault_q <= FLT_NONE;
            st_q    <= S_DONE;
          end else if (cmd_ready_i) begin
            cur_q <= nxt_idx + 1'b1;
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o       = (st_q == S_READ);
  assign rd_addr_o      = base_q + ADDR_W'({wcnt_q, {BSH{1'b0}}});
  assign cmd_valid_o    = (st_q == S_ISSUE) && nxt_found;
  assign cmd_idx_o      = nxt_idx;
  assign cmd_load_o     = state_q[nxt_idx];
  assign cmd_csr_init_o = cmd_valid_o && !cmd_load_o && (nxt_idx == IW'(CSR_IDX));
  assign csr_val_o      = cmd_csr_init_o ? CSR_W'(CSR_INIT) : '0;
  assign busy_o         = (st_q != S_IDLE);
  assign done_o         = (st_q == S_DONE);
  assign fault_o        = fault_q;

  // R7: command held while stalled
  a_r7_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_idx_o) && $stable(cmd_load_o));

  // R7: strictly ascending indices
  a_r7_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o || (cmd_idx_o > $past(cmd_idx_o)));

  // R6: a load never targets a component absent from the compaction vector
  a_r6_load_in_comp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_load_o |-> comp_q[cmd_idx_o]);

  // R8: initial value travels only with an init of component CSR_IDX
  a_r8_csr_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_csr_init_o |-> cmd_valid_o && !cmd_load_o && csr_val_o == CSR_W'(CSR_INIT));

  // R9: done is quiet and a single pulse
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o && !rd_req_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_restore_seq.sv
`timescale 1ns/100ps
module sim_restore_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] imask = '0, uen = '0, sen = '0, addr = '0;
  logic [1:0]  priv = '0;
  logic        ee = 1'b1, ts = 1'b0;
  logic        rd_req, rd_valid = 1'b0;
  logic [63:0] rd_addr, rd_data = '0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_load, csr_init, busy, done;
  logic [5:0]  cmd_idx;
  logic [31:0] csr_val;
  logic [1:0]  fault;

  int total = 0, fails = 0, cyc = 0;
  int exp_q[$];
  int exp_fault = 0, exp_reads = 0, rd_cnt = 0;
  bit addr_bad = 0, done_seen = 0;
  logic [63:0] mem [8];
  logic [63:0] base_e = '0;

  always #2.5 clk = ~clk;

  restore_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .instr_mask_i(imask), .user_en_i(uen), .sup_en_i(sen),
    .priv_i(priv), .ext_en_i(ee), .task_sw_i(ts), .area_addr_i(addr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_load_o(cmd_load),
    .cmd_idx_o(cmd_idx), .cmd_csr_init_o(csr_init), .csr_val_o(csr_val),
    .busy_o(busy), .done_o(done), .fault_o(fault)
  );

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // stimulus responders, driven at negedge
  always @(negedge clk) begin
    cyc++;
    cmd_ready <= (cyc % 3 != 1);
    if (rd_req && (cyc % 2 == 0)) begin
      int w;
      w = int'((rd_addr - base_e) >> 3);
      rd_valid <= 1'b1;
      rd_data  <= (w >= 0 && w < 8) ? mem[w] : 64'hDEAD;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end
  end

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (rd_req && rd_valid) begin
        if (rd_addr != base_e + 64'(rd_cnt * 8)) addr_bad = 1;
        rd_cnt++;
      end
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", $sformatf("unexpected cmd idx=%0d load=%0b, expected none", cmd_idx, cmd_load));
        end else begin
          int e;
          e = exp_q.pop_front();
          check(cmd_idx == 6'(e & 63) && cmd_load == e[8], "R7",
            $sformatf("cmd idx=%0d load=%0b, expected idx=%0d load=%0b", cmd_idx, cmd_load, e & 63, e[8]));
          if (cmd_idx == 6'd1 && !cmd_load)
            check(csr_init && csr_val == 32'h1F80, "R8",
              $sformatf("csr_init=%0b val=%h, expected 1 1f80", csr_init, csr_val));
          else
            check(!csr_init, "R8", $sformatf("csr_init=%0b, expected 0", csr_init));
        end
      end
      if (done) begin
        check(int'(fault) == exp_fault, "R9", $sformatf("fault=%0d, expected %0d", fault, exp_fault));
        check(exp_q.size() == 0, "R7", $sformatf("%0d commands missing, expected 0", exp_q.size()));
        done_seen = 1;
      end
    end
  end

  task automatic model(input logic [63:0] im, ue, se, input logic [1:0] pr,
                       input logic e, t, input logic [63:0] a);
    logic [63:0] rf, en, sv, cv;
    bit tail;
    rf = im & (ue | se);                   // R1
    en = ue | se;
    exp_q.delete();
    exp_reads = 0;
    if (!e) exp_fault = 1;                 // R2
    else if (t) exp_fault = 2;             // R3
    else if (pr != 0 || a[5:0] != 0) exp_fault = 3;  // R4
    else begin
      exp_reads = 8;                       // R5
      sv = mem[0];
      cv = mem[1];
      tail = 0;
      for (int k = 2; k < 8; k++) if (mem[k] != 0) tail = 1;
      if (!cv[63] || (cv[62:0] & ~en[62:0]) != 0 || (sv & ~cv) != 0 || tail) exp_fault = 3; // R6
      else begin
        exp_fault = 0;
        for (int i = 0; i < 63; i++)
          if (rf[i]) exp_q.push_back((sv[i] ? 256 : 0) | i);
      end
    end
  endtask

  task automatic run(input logic [63:0] im, ue, se, input logic [1:0] pr,
                     input logic e, t, input logic [63:0] a, input bit restart);
    bit got;
    model(im, ue, se, pr, e, t, a);
    @(negedge clk);
    imask = im; uen = ue; sen = se; priv = pr; ee = e; ts = t; addr = a;
    base_e = a; rd_cnt = 0; addr_bad = 0; done_seen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int k = 0; k < 3000; k++) begin
      if (done_seen) begin got = 1; break; end
      if (restart && k == 3) begin ee = 1'b0; imask = '0; start = 1'b1; end  // R10
      if (restart && k == 4) begin ee = e; imask = im; start = 1'b0; end
      @(negedge clk);
    end
    check(got, "R9", $sformatf("done seen=%0b, expected 1", got));
    check(rd_cnt == exp_reads && !addr_bad, "R5",
      $sformatf("reads=%0d addr_bad=%0b, expected %0d 0", rd_cnt, addr_bad, exp_reads));
    if (restart) check(!busy, "R10", $sformatf("busy=%0b after run, expected 0", busy));
  endtask

  task automatic hdr(input logic [63:0] s, c);
    mem[0] = s;
    mem[1] = c;
    for (int k = 2; k < 8; k++) mem[k] = '0;
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    hdr(64'h15, 64'h8000_0000_0000_003F);
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !cmd_valid && !rd_req, "R9",
      $sformatf("reset outs busy=%0b done=%0b cv=%0b rq=%0b, expected 0", busy, done, cmd_valid, rd_req));
    rst_n = 1'b1;
    // R2 over everything else
    run('1, 64'h3F, 0, 2'd3, 0, 1, 64'h1008, 0);
    // R3 over privilege and alignment
    run('1, 64'h3F, 0, 2'd3, 1, 1, 64'h1008, 0);
    // R4 privilege, then alignment
    run('1, 64'h3F, 0, 2'd2, 1, 0, 64'h1000, 0);
    run('1, 64'h3F, 0, 2'd0, 1, 0, 64'h1008, 0);
    // R6 header rules
    hdr(64'h15, 64'h3F);
    run('1, 64'h3F, 0, 0, 1, 0, 64'h2000, 0);
    hdr(64'h15, 64'h8000_0100_0000_003F);
    run('1, 64'h3F, 0, 0, 1, 0, 64'h2000, 0);
    hdr(64'h35, 64'h8000_0000_0000_001F);
    run('1, 64'h3F, 0, 0, 1, 0, 64'h2000, 0);
    hdr(64'h15, 64'h8000_0000_0000_003F);
    mem[6] = 64'h100;
    run('1, 64'h3F, 0, 0, 1, 0, 64'h2000, 0);
    // R7 R8 R1: mixed init/load, enables split across user and supervisor
    hdr(64'h15, 64'h8000_0000_0000_003F);
    run('1, 64'h0F, 64'h30, 0, 1, 0, 64'h2040, 0);
    // R7: init of component 1 with compaction bit clear, mask restricts set
    hdr(64'h8, 64'h8000_0000_0000_0038);
    run(64'h0A, 64'hFF, 0, 0, 1, 0, 64'h3000, 0);
    // R1: component 62 and state bit 63, bit 63 of mask gives no command
    hdr(64'hC000_0000_0000_0001, 64'hC000_0000_0000_0001);
    run('1, 64'hC000_0000_0000_0001, 0, 0, 1, 0, 64'h4000, 0);
    // R9: empty requested set
    hdr(64'h1, 64'h8000_0000_0000_0001);
    run(64'h0, 64'h1, 0, 0, 1, 0, 64'h4040, 0);
    // R10: restart pulse mid-run ignored
    hdr(64'h6, 64'h8000_0000_0000_0007);
    run('1, 64'h7, 0, 0, 1, 0, 64'h5000, 1);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule